// File: doc/BRIEF.md
# Register Renaming Map Unit

This block turns the logical register numbers of an instruction into physical register numbers, one instruction per cycle. Each instruction presents two logical source registers and, if it writes a result, one logical destination register. The sources are looked up in a map table and come back as physical registers in the same cycle. A writing instruction takes a fresh physical register from a free list, and that register becomes the new mapping of its logical destination at the next clock edge. Because every write lands in a register of its own, write-after-write and write-after-read conflicts between instructions disappear. Only true producer-to-consumer dependencies remain, and those show up as matching physical numbers.

The unit also reports the physical register that the destination was mapped to before the write. The surrounding pipeline keeps that value and hands it back on the release port once the newer write commits. Released registers join the tail of the free list and are handed out again in first-in, first-out order. When the free list is empty, a writing instruction is held off with a stall output, and neither the map nor the list changes.

Top module: `reg_rename_unit`

## Requirements
- R1: After a synchronous active-low reset, logical register i maps to physical register i. The free list then holds physical registers NUM_LOG up to NUM_PHYS-1 in ascending order, and stall is low.
- R2: `out_phys_a` and `out_phys_b` are combinational lookups of the current map for `in_src_a` and `in_src_b`. They are valid in the same cycle as the request, whether or not `in_valid` is high.
- R3: A writing instruction that is accepted (`in_valid`=1, `in_has_dst`=1, `stall`=0) receives the physical register at the head of the free list on `out_phys_dst`. Registers are granted in free-list order: ascending from reset, then in the order they were released.
- R4: From the cycle after an accepted write, every source lookup of that logical register returns the newly granted physical register.
- R5: An instruction that reads and writes the same logical register reads the mapping that was in place before its own write.
- R6: `out_prev_dst` shows the mapping of `in_dst` as it stands before the instruction's own update.
- R7: An instruction with `in_has_dst`=0 takes no physical register, leaves the map unchanged and is never stalled.
- R8: `stall` is high exactly when `in_valid`=1, `in_has_dst`=1 and the free list is empty. A stalled cycle changes neither the map nor the free list, apart from a release in that cycle.
- R9: `rel_valid`=1 appends `rel_phys` to the tail of the free list. A release and an allocation in the same cycle both take effect. A released register can be granted only from the following cycle.
- R10: In the sequence R3=R3+R5, R4=R3+1, R3=R5+1, R7=R3+R4, the two writes of R3 get different physical registers. The second instruction reads the first write of R3, and the fourth reads the second write.
- R11: With `in_valid`=0, the map and the free list stay unchanged, apart from a release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_has_dst | input | 1 | The instruction writes a destination register |
| in_src_a | input | $clog2(NUM_LOG) | First logical source register |
| in_src_b | input | $clog2(NUM_LOG) | Second logical source register |
| in_dst | input | $clog2(NUM_LOG) | Logical destination register |
| rel_valid | input | 1 | Return a physical register to the free list |
| rel_phys | input | $clog2(NUM_PHYS) | Physical register being returned |
| out_phys_a | output | $clog2(NUM_PHYS) | Physical register for the first source |
| out_phys_b | output | $clog2(NUM_PHYS) | Physical register for the second source |
| out_phys_dst | output | $clog2(NUM_PHYS) | Physical register granted to the destination (head of the free list) |
| out_prev_dst | output | $clog2(NUM_PHYS) | Mapping of the destination before this instruction's write |
| stall | output | 1 | Writing instruction refused because no physical register is free |

## Verification
The assertions take for granted that the release port is used honestly. Each register that is returned was granted earlier and has since been superseded, so releases never exceed allocations, the free list never overflows and no register is on the list twice. The vector table and the directed tests keep to this rule: every release names a physical register whose logical register has already been rewritten. No test releases more registers than have left the free list since reset.

// File: rtl/reg_rename_pkg.sv
`timescale 1ns/1ps
// Package reg_rename_pkg
// Shared default sizes and helper functions for the register renaming unit.
// Assumes NUM_PHYS is strictly larger than NUM_LOG.
package reg_rename_pkg;

    localparam int RN_NUM_LOG  = 8;
    localparam int RN_NUM_PHYS = 16;

    // Number of physical registers left over for the free list after reset.
    function automatic int spare_regs(input int num_log, input int num_phys);
        return num_phys - num_log;
    endfunction

    // Advance a circular pointer with wrap at depth-1 (depth need not be a power of two).
    function automatic int wrap_next(input int ptr, input int depth);
        return (ptr == depth - 1) ? 0 : ptr + 1;
    endfunction

endpackage

// File: rtl/rename_map_table.sv
`timescale 1ns/1ps
// Module rename_map_table
// Holds the logical-to-physical register map. It offers NUM_RD combinational
// read ports and one synchronous write port. Reads always see the value from
// before this cycle's write, so a same-cycle read-and-write returns the old
// mapping. After reset, logical register i maps to physical register i.
// Assumes the write index is a valid logical register number.
module rename_map_table #(
    parameter int NUM_LOG  = 8,
    parameter int NUM_PHYS = 16,
    parameter int NUM_RD   = 3,
    localparam int LW = $clog2(NUM_LOG),
    localparam int PW = $clog2(NUM_PHYS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_RD-1:0][LW-1:0]    rd_idx,
    output logic [NUM_RD-1:0][PW-1:0]    rd_phys,
    input  logic                         wr_en,
    input  logic [LW-1:0]                wr_idx,
    input  logic [PW-1:0]                wr_phys,
    output logic [NUM_LOG-1:0][PW-1:0]   map_view
);

    logic [NUM_LOG-1:0][PW-1:0] map_q;

    // Update one entry per accepted write; reset restores the identity mapping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LOG; i++) begin
                map_q[i] <= PW'(i);
            end
        end else if (wr_en) begin
            map_q[wr_idx] <= wr_phys;
        end
    end

    // One combinational lookup per read port.
    for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
        always_comb begin
            rd_phys[g] = map_q[rd_idx[g]];
        end
    end

    // Expose the whole table for checking.
    always_comb begin
        map_view = map_q;
    end

endmodule

// File: rtl/rename_free_list.sv
`timescale 1ns/1ps
// Module rename_free_list
// Circular FIFO of free physical register numbers. The head entry is always
// visible, pop removes it, and push appends at the tail. Push and pop may
// happen in the same cycle. After reset it holds NUM_LOG up to NUM_PHYS-1 in
// ascending order. Assumes the caller never pops while empty and never pushes
// more registers than it has popped.
module rename_free_list #(
    parameter int NUM_LOG  = 8,
    parameter int NUM_PHYS = 16,
    localparam int PW    = $clog2(NUM_PHYS),
    localparam int PTRW  = (NUM_PHYS > 1) ? $clog2(NUM_PHYS) : 1,
    localparam int CW    = $clog2(NUM_PHYS + 1),
    localparam int SPARE = reg_rename_pkg::spare_regs(NUM_LOG, NUM_PHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic          push,
    input  logic [PW-1:0] push_phys,
    output logic [PW-1:0] head_phys,
    output logic          empty,
    output logic [CW-1:0] count
);

    logic [NUM_PHYS-1:0][PW-1:0] slot_q;
    logic [PTRW-1:0]             head_q;
    logic [PTRW-1:0]             tail_q;
    logic [CW-1:0]               cnt_q;
    logic [PTRW-1:0]             head_nx;
    logic [PTRW-1:0]             tail_nx;

    // Next-pointer values with wrap at the end of the storage.
    always_comb begin
        head_nx = PTRW'(reg_rename_pkg::wrap_next(int'(head_q), NUM_PHYS));
        tail_nx = PTRW'(reg_rename_pkg::wrap_next(int'(tail_q), NUM_PHYS));
    end

    // Storage: preload the spare registers on reset, write released ones at the tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PHYS; i++) begin
                slot_q[i] <= (i < SPARE) ? PW'(NUM_LOG + i) : '0;
            end
        end else if (push) begin
            slot_q[tail_q] <= push_phys;
        end
    end

    // Pointer and occupancy bookkeeping for push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= PTRW'(SPARE % NUM_PHYS);
            cnt_q  <= CW'(SPARE);
        end else begin
            if (pop) begin
                head_q <= head_nx;
            end
            if (push) begin
                tail_q <= tail_nx;
            end
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Head value and status outputs.
    always_comb begin
        head_phys = slot_q[head_q];
        empty     = (cnt_q == '0);
        count     = cnt_q;
    end

endmodule

// File: rtl/reg_rename_unit.sv
`timescale 1ns/1ps
// Module reg_rename_unit
// Renames one instruction per cycle. The source lookups and the previous
// destination mapping come out combinationally. An accepted writing
// instruction takes the head of the free list as its new physical register,
// and the map is updated at the clock edge. With an empty free list, a writing
// instruction is stalled and no state changes. Registers come back through the
// release port. Assumes released registers are superseded and not already free.
module reg_rename_unit #(
    parameter int NUM_LOG  = reg_rename_pkg::RN_NUM_LOG,
    parameter int NUM_PHYS = reg_rename_pkg::RN_NUM_PHYS,
    localparam int LW = $clog2(NUM_LOG),
    localparam int PW = $clog2(NUM_PHYS),
    localparam int CW = $clog2(NUM_PHYS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_has_dst,
    input  logic [LW-1:0] in_src_a,
    input  logic [LW-1:0] in_src_b,
    input  logic [LW-1:0] in_dst,
    input  logic          rel_valid,
    input  logic [PW-1:0] rel_phys,
    output logic [PW-1:0] out_phys_a,
    output logic [PW-1:0] out_phys_b,
    output logic [PW-1:0] out_phys_dst,
    output logic [PW-1:0] out_prev_dst,
    output logic          stall
);

    localparam int NUM_RD = 3;

    logic [NUM_RD-1:0][LW-1:0]  rd_idx;
    logic [NUM_RD-1:0][PW-1:0]  rd_phys;
    logic [NUM_LOG-1:0][PW-1:0] map_view;
    logic [PW-1:0]              fl_head;
    logic                       fl_empty;
    logic [CW-1:0]              fl_count;
    logic                       want_alloc;
    logic                       do_alloc;

    // Gather the lookup indices: two sources plus the destination's old mapping.
    always_comb begin
        rd_idx[0] = in_src_a;
        rd_idx[1] = in_src_b;
        rd_idx[2] = in_dst;
    end

    // Decide whether this cycle allocates or stalls.
    always_comb begin
        want_alloc = in_valid && in_has_dst;
        do_alloc   = want_alloc && !fl_empty;
        stall      = want_alloc && fl_empty;
    end

    // Drive the renamed operands.
    always_comb begin
        out_phys_a   = rd_phys[0];
        out_phys_b   = rd_phys[1];
        out_prev_dst = rd_phys[2];
        out_phys_dst = fl_head;
    end

    rename_map_table #(
        .NUM_LOG  (NUM_LOG),
        .NUM_PHYS (NUM_PHYS),
        .NUM_RD   (NUM_RD)
    ) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_idx),
        .rd_phys  (rd_phys),
        .wr_en    (do_alloc),
        .wr_idx   (in_dst),
        .wr_phys  (fl_head),
        .map_view (map_view)
    );

    rename_free_list #(
        .NUM_LOG  (NUM_LOG),
        .NUM_PHYS (NUM_PHYS)
    ) u_free (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop       (do_alloc),
        .push      (rel_valid),
        .push_phys (rel_phys),
        .head_phys (fl_head),
        .empty     (fl_empty),
        .count     (fl_count)
    );

endmodule

// File: rtl/reg_rename_chk.sv
`timescale 1ns/1ps
// Module reg_rename_chk
// Property checks for reg_rename_unit, attached through bind. Relates the
// port activity to the free-list occupancy and the map contents over time.
// Assumes legal releases (see the brief).
module reg_rename_chk #(
    parameter int NUM_LOG  = 8,
    parameter int NUM_PHYS = 16,
    localparam int LW = $clog2(NUM_LOG),
    localparam int PW = $clog2(NUM_PHYS),
    localparam int CW = $clog2(NUM_PHYS + 1)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_valid,
    input logic                       in_has_dst,
    input logic [LW-1:0]              in_dst,
    input logic                       rel_valid,
    input logic                       stall,
    input logic [PW-1:0]              out_phys_dst,
    input logic [CW-1:0]              free_cnt,
    input logic [NUM_LOG-1:0][PW-1:0] map_flat
);

    logic alloc_ok;

    // Accepted writing instruction as seen at the ports.
    always_comb begin
        alloc_ok = in_valid && in_has_dst && !stall;
    end

    // R3
    alloc_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_ok && !rel_valid) |=> free_cnt == $past(free_cnt) - CW'(1));

    // R9
    release_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && !alloc_ok) |=> free_cnt == $past(free_cnt) + CW'(1));

    // R9
    swap_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && alloc_ok) |=> $stable(free_cnt));

    // R8
    stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !rel_valid) |=> ($stable(free_cnt) && $stable(map_flat)));

    // R4
    map_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_ok |=> map_flat[$past(in_dst)] == $past(out_phys_dst));

    // R7
    nodst_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_has_dst) |=> $stable(map_flat));

    // R11
    idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !rel_valid) |=> ($stable(map_flat) && $stable(free_cnt)));

endmodule

bind reg_rename_unit reg_rename_chk #(
    .NUM_LOG  (NUM_LOG),
    .NUM_PHYS (NUM_PHYS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_has_dst   (in_has_dst),
    .in_dst       (in_dst),
    .rel_valid    (rel_valid),
    .stall        (stall),
    .out_phys_dst (out_phys_dst),
    .free_cnt     (fl_count),
    .map_flat     (map_view)
);

// File: tb/reg_rename_unit_bench.sv
`timescale 1ns/1ps
// Bench for reg_rename_unit at default sizes (8 logical, 16 physical).
// Walks a vector table, then runs directed reset and exhaustion tests.
module reg_rename_unit_bench;

    localparam int LW = 3;
    localparam int PW = 4;
    localparam int NV = 18;

    typedef struct packed {
        logic [7:0]    req;
        logic          v;
        logic          hd;
        logic [LW-1:0] sa;
        logic [LW-1:0] sb;
        logic [LW-1:0] d;
        logic          rv;
        logic [PW-1:0] rp;
        logic [PW-1:0] ea;
        logic [PW-1:0] eb;
        logic [PW-1:0] ed;
        logic [PW-1:0] eo;
        logic          es;
        logic          ced;
    } vec_t;

    function automatic vec_t mk(input int req, input int v, input int hd, input int sa,
                                input int sb, input int d, input int rv, input int rp,
                                input int ea, input int eb, input int ed, input int eo,
                                input int es, input int ced);
        vec_t r;
        r.req = 8'(req);  r.v  = 1'(v);   r.hd = 1'(hd);
        r.sa  = LW'(sa);  r.sb = LW'(sb); r.d  = LW'(d);
        r.rv  = 1'(rv);   r.rp = PW'(rp);
        r.ea  = PW'(ea);  r.eb = PW'(eb); r.ed = PW'(ed); r.eo = PW'(eo);
        r.es  = 1'(es);   r.ced = 1'(ced);
        return r;
    endfunction

    // Fields: req, valid, has_dst, src_a, src_b, dst, rel_valid, rel_phys,
    //         exp_a, exp_b, exp_dst, exp_prev, exp_stall, check_dst
    localparam vec_t VEC [NV] = '{
        mk(10, 1,1, 3,5,3, 0,0,  3, 5, 8, 3, 0,1), // R10 R3=R3+R5
        mk( 4, 1,1, 3,0,4, 0,0,  8, 0, 9, 4, 0,1), // R4 R4=R3+1 reads new R3
        mk(10, 1,1, 5,0,3, 0,0,  5, 0,10, 8, 0,1), // R10 R3=R5+1 fresh register
        mk(10, 1,1, 3,4,7, 0,0, 10, 9,11, 7, 0,1), // R10 R7=R3+R4 reads second R3
        mk( 7, 1,0, 7,3,3, 0,0, 11,10, 0,10, 0,0), // R7 no destination
        mk(11, 0,1, 3,0,3, 0,0, 10, 0,12,10, 0,1), // R11 invalid, lookup only (R2)
        mk( 5, 1,1, 3,3,3, 0,0, 10,10,12,10, 0,1), // R5 read and write R3
        mk( 3, 1,1, 3,1,1, 0,0, 12, 1,13, 1, 0,1), // R3 next grant
        mk( 6, 1,1, 2,2,2, 0,0,  2, 2,14, 2, 0,1), // R6 previous mapping
        mk( 3, 1,1, 5,6,5, 0,0,  5, 6,15, 5, 0,1), // R3 last spare register
        mk( 8, 1,1, 6,5,6, 0,0,  6,15, 0, 6, 1,0), // R8 list empty
        mk( 7, 1,0, 6,1,0, 0,0,  6,13, 0, 0, 0,0), // R7 no stall without destination
        mk( 9, 1,1, 6,0,6, 1,3,  6, 0, 0, 6, 1,0), // R9 release not usable same cycle
        mk( 9, 1,1, 6,6,6, 0,0,  6, 6, 3, 6, 0,1), // R9 released register granted
        mk( 9, 0,0, 0,0,0, 1,8,  0, 0, 0, 0, 0,0), // R9 release while idle
        mk( 9, 1,1, 6,0,0, 1,10, 3, 0, 8, 0, 0,1), // R9 release and grant together
        mk( 4, 1,1, 4,7,4, 0,0,  9,11,10, 9, 0,1), // R4 FIFO order of releases
        mk( 4, 0,0, 0,3,0, 0,0,  8,12, 0, 8, 0,0)  // R4 final map check
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_has_dst = 1'b0;
    logic [LW-1:0] in_src_a = '0;
    logic [LW-1:0] in_src_b = '0;
    logic [LW-1:0] in_dst = '0;
    logic          rel_valid = 1'b0;
    logic [PW-1:0] rel_phys = '0;
    logic [PW-1:0] out_phys_a;
    logic [PW-1:0] out_phys_b;
    logic [PW-1:0] out_phys_dst;
    logic [PW-1:0] out_prev_dst;
    logic          stall;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    reg_rename_unit u_reg_rename_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_has_dst   (in_has_dst),
        .in_src_a     (in_src_a),
        .in_src_b     (in_src_b),
        .in_dst       (in_dst),
        .rel_valid    (rel_valid),
        .rel_phys     (rel_phys),
        .out_phys_a   (out_phys_a),
        .out_phys_b   (out_phys_b),
        .out_phys_dst (out_phys_dst),
        .out_prev_dst (out_prev_dst),
        .stall        (stall)
    );

    task automatic chk(input int req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input int v, input int hd, input int sa, input int sb,
                         input int d, input int rv, input int rp);
        in_valid   = 1'(v);
        in_has_dst = 1'(hd);
        in_src_a   = LW'(sa);
        in_src_b   = LW'(sb);
        in_dst     = LW'(d);
        rel_valid  = 1'(rv);
        rel_phys   = PW'(rp);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // Reset
        drive(0, 0, 0, 0, 0, 0, 0);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Vector table walk: drive at negedge, sample before the next rising edge
        for (int k = 0; k < NV; k++) begin
            drive(int'(VEC[k].v), int'(VEC[k].hd), int'(VEC[k].sa), int'(VEC[k].sb),
                  int'(VEC[k].d), int'(VEC[k].rv), int'(VEC[k].rp));
            #5;
            chk(int'(VEC[k].req), $sformatf("vec%0d src_a", k), int'(out_phys_a), int'(VEC[k].ea));
            chk(int'(VEC[k].req), $sformatf("vec%0d src_b", k), int'(out_phys_b), int'(VEC[k].eb));
            chk(int'(VEC[k].req), $sformatf("vec%0d prev", k), int'(out_prev_dst), int'(VEC[k].eo));
            chk(int'(VEC[k].req), $sformatf("vec%0d stall", k), int'(stall), int'(VEC[k].es));
            if (VEC[k].ced) begin
                chk(int'(VEC[k].req), $sformatf("vec%0d dst", k), int'(out_phys_dst), int'(VEC[k].ed));
            end
            @(negedge clk);
        end

        // R1: reset mid-run restores the identity map and the full free list
        drive(0, 0, 0, 0, 0, 0, 0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            in_src_a = LW'(i);
            #1;
            chk(1, $sformatf("identity r%0d", i), int'(out_phys_a), i);
        end
        drive(1, 1, 0, 0, 0, 0, 0);
        #1;
        chk(1, "stall after reset", int'(stall), 0);
        chk(1, "first grant after reset", int'(out_phys_dst), 8);
        @(negedge clk);

        // R3/R6: the first instruction above was granted 8; grant the rest in order
        for (int i = 1; i < 8; i++) begin
            drive(1, 1, 0, 0, i, 0, 0);
            #5;
            chk(3, $sformatf("grant %0d", i), int'(out_phys_dst), 8 + i);
            chk(6, $sformatf("prev of r%0d", i), int'(out_prev_dst), i);
            @(negedge clk);
        end

        // R8: exhausted list stalls a writer, and the map stays put
        drive(1, 1, 0, 0, 3, 0, 0);
        #5;
        chk(8, "stall when empty", int'(stall), 1);
        @(negedge clk);
        drive(0, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 8; i++) begin
            in_src_a = LW'(i);
            #1;
            chk(4, $sformatf("map r%0d after fill", i), int'(out_phys_a), 8 + i);
        end

        @(negedge clk);
        finish_run();
    end

endmodule